// File: doc/BRIEF.md
# DMA Chain Tag Address Sequencer

This block holds the address state of a source-chain DMA channel that follows a linked list of 128-bit tags in memory. Each time the fetch logic has read a tag, it presents the tag's kind, its quadword count and its address field for one cycle. The sequencer then places the data pointer where the packet's payload lives and moves the tag pointer to the next tag. It also reports whether the chain stops after this packet.

The data mover pulses a step strobe for each quadword it moves. The sequencer advances the data pointer by one quadword per step and counts the packet's remaining quadwords down. When the mover signals that a packet is complete, and that packet came from a count-style tag, the tag pointer is set to the final data pointer. Software that polls the tag pointer can then see the transfer progress.

A start strobe sets the tag pointer to the first tag of a new chain.

Top module: `dma_chain_seq`

## Requirements
- R1: While reset is asserted, and after it is released, dataPtr, tagPtr and qwcLeft are 0 and chainEnd is 0.
- R2: chainStart loads tagPtr from startPtr, clears qwcLeft and chainEnd, and leaves dataPtr unchanged. It takes priority over tagValid, qwStep and dataDone in the same cycle.
- R3: Tag kinds are encoded on tagId as follows: 0 reference-and-stop, 1 count, 2 jump, 3 reference, 7 stop. Codes 4, 5 and 6 leave dataPtr, tagPtr and qwcLeft unchanged and set chainEnd.
- R4: A reference-and-stop tag (0) loads dataPtr from tagAddr, advances tagPtr by 16, and sets chainEnd.
- R5: A count tag (1) sets dataPtr to tagPtr+16, sets tagPtr to the same value, and clears chainEnd.
- R6: A jump tag (2) sets dataPtr to tagPtr+16, loads tagPtr from tagAddr, and clears chainEnd.
- R7: A reference tag (3) loads dataPtr from tagAddr, advances tagPtr by 16, and clears chainEnd.
- R8: A stop tag (7) sets dataPtr to tagPtr+16, leaves tagPtr unchanged, and sets chainEnd.
- R9: When qwStep is high and qwcLeft is nonzero, dataPtr advances by 16 and qwcLeft falls by one. When qwcLeft is 0, qwStep is ignored.
- R10: dataDone after a count-tag packet loads tagPtr with dataPtr, including any step taken in the same cycle. After any other tag kind, dataDone has no effect.
- R11: All outputs are registered. chainEnd reflects a tag in the cycle after its strobe and holds its value until the next tag or start.
- R12: Every supported tag loads qwcLeft from tagQwc. A tag strobe takes priority over qwStep and dataDone in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| chainStart | input | 1 | Begin a new chain at startPtr |
| startPtr | input | ADDR_W | Address of the first tag |
| tagValid | input | 1 | A fetched tag is presented this cycle |
| tagId | input | 3 | Tag kind code |
| tagQwc | input | QWC_W | Packet length in quadwords |
| tagAddr | input | ADDR_W | Address field of the tag |
| qwStep | input | 1 | One quadword was moved |
| dataDone | input | 1 | The current packet is complete |
| dataPtr | output | ADDR_W | Data address register |
| tagPtr | output | ADDR_W | Tag address register |
| qwcLeft | output | QWC_W | Quadwords remaining in the packet |
| chainEnd | output | 1 | The chain stops after this packet |

## Verification
The assertions assume that at most one of chainStart and tagValid is acted on per cycle. A tag check is therefore conditioned on chainStart being low, and a step check is conditioned on both chainStart and tagValid being low. No check assumes that the strobes are exclusive. The stimulus still drives overlapping strobes on purpose, to exercise the priority order. Addresses are kept well below the wrap point, so a +16 step never overflows.

// File: rtl/dma_chain_seq_pkg.sv
package dma_chain_seq_pkg;
  localparam int ID_W = 3;
  localparam logic [ID_W-1:0] KIND_REF_LAST = 3'd0;
  localparam logic [ID_W-1:0] KIND_COUNT    = 3'd1;
  localparam logic [ID_W-1:0] KIND_JUMP     = 3'd2;
  localparam logic [ID_W-1:0] KIND_REF      = 3'd3;
  localparam logic [ID_W-1:0] KIND_STOP     = 3'd7;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadStart;
    logic tagLoad;
    logic madrFromAddr;
    logic tadrFromAddr;
    logic tadrInc;
    logic endVal;
    logic endOnly;
    logic madrStep;
    logic tadrFollow;
  } seqCtrl_t;
endpackage

// File: rtl/dma_chain_seq_ctrl.sv
module dma_chain_seq_ctrl
  import dma_chain_seq_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            chainStart,
  input  logic            tagValid,
  input  logic [ID_W-1:0] tagId,
  input  logic            qwStep,
  input  logic            dataDone,
  input  logic            qwcZero,
  output seqCtrl_t        ctrl
);
  logic lastWasCount;

  always_comb begin
    ctrl = '0;
    ctrl.loadStart = chainStart;
    if (!chainStart && tagValid) begin
      unique case (tagId)
        KIND_REF_LAST: begin
          ctrl.tagLoad = 1'b1; ctrl.madrFromAddr = 1'b1;
          ctrl.tadrInc = 1'b1; ctrl.endVal = 1'b1;
        end
        KIND_COUNT: begin
          ctrl.tagLoad = 1'b1; ctrl.tadrInc = 1'b1;
        end
        KIND_JUMP: begin
          ctrl.tagLoad = 1'b1; ctrl.tadrFromAddr = 1'b1;
        end
        KIND_REF: begin
          ctrl.tagLoad = 1'b1; ctrl.madrFromAddr = 1'b1; ctrl.tadrInc = 1'b1;
        end
        KIND_STOP: begin
          ctrl.tagLoad = 1'b1; ctrl.endVal = 1'b1;
        end
        default: ctrl.endOnly = 1'b1;
      endcase
    end else if (!chainStart) begin
      ctrl.madrStep   = qwStep && !qwcZero;
      ctrl.tadrFollow = dataDone && lastWasCount;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || chainStart) lastWasCount <= 1'b0;
    else if (tagValid)       lastWasCount <= (tagId == KIND_COUNT);
  end
endmodule

// File: rtl/dma_chain_seq_dp.sv
module dma_chain_seq_dp
  import dma_chain_seq_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int QWC_W    = 16,
  parameter int QW_BYTES = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqCtrl_t          ctrl,
  input  logic [ADDR_W-1:0] startPtr,
  input  logic [ADDR_W-1:0] tagAddr,
  input  logic [QWC_W-1:0]  tagQwc,
  output logic [ADDR_W-1:0] dataPtr,
  output logic [ADDR_W-1:0] tagPtr,
  output logic [QWC_W-1:0]  qwcLeft,
  output logic              chainEnd,
  output logic              qwcZero
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(QW_BYTES);

  logic [ADDR_W-1:0] afterTag;
  logic [ADDR_W-1:0] dataNext;

  assign afterTag = tagPtr + STEP;
  assign dataNext = dataPtr + STEP;
  assign qwcZero  = (qwcLeft == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataPtr  <= '0;
      tagPtr   <= '0;
      qwcLeft  <= '0;
      chainEnd <= 1'b0;
    end else if (ctrl.loadStart) begin
      tagPtr   <= startPtr;
      qwcLeft  <= '0;
      chainEnd <= 1'b0;
    end else if (ctrl.tagLoad) begin
      qwcLeft  <= tagQwc;
      chainEnd <= ctrl.endVal;
      dataPtr  <= ctrl.madrFromAddr ? tagAddr : afterTag;
      if (ctrl.tadrFromAddr)  tagPtr <= tagAddr;
      else if (ctrl.tadrInc)  tagPtr <= afterTag;
    end else if (ctrl.endOnly) begin
      chainEnd <= 1'b1;
    end else begin
      if (ctrl.madrStep) begin
        dataPtr <= dataNext;
        qwcLeft <= qwcLeft - QWC_W'(1);
      end
      if (ctrl.tadrFollow) tagPtr <= ctrl.madrStep ? dataNext : dataPtr;
    end
  end
endmodule

// File: rtl/dma_chain_seq.sv
module dma_chain_seq
  import dma_chain_seq_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int QWC_W    = 16,
  parameter int QW_BYTES = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              chainStart,
  input  logic [ADDR_W-1:0] startPtr,
  input  logic              tagValid,
  input  logic [2:0]        tagId,
  input  logic [QWC_W-1:0]  tagQwc,
  input  logic [ADDR_W-1:0] tagAddr,
  input  logic              qwStep,
  input  logic              dataDone,
  output logic [ADDR_W-1:0] dataPtr,
  output logic [ADDR_W-1:0] tagPtr,
  output logic [QWC_W-1:0]  qwcLeft,
  output logic              chainEnd
);
  seqCtrl_t ctrl;
  logic     qwcZero;

  dma_chain_seq_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .chainStart(chainStart), .tagValid(tagValid),
    .tagId(tagId), .qwStep(qwStep), .dataDone(dataDone), .qwcZero(qwcZero),
    .ctrl(ctrl)
  );

  dma_chain_seq_dp #(.ADDR_W(ADDR_W), .QWC_W(QWC_W), .QW_BYTES(QW_BYTES)) dp_i (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .startPtr(startPtr), .tagAddr(tagAddr),
    .tagQwc(tagQwc), .dataPtr(dataPtr), .tagPtr(tagPtr), .qwcLeft(qwcLeft),
    .chainEnd(chainEnd), .qwcZero(qwcZero)
  );
endmodule

// File: rtl/dma_chain_seq_checker.sv
module dma_chain_seq_checker #(
  parameter int ADDR_W   = 32,
  parameter int QWC_W    = 16,
  parameter int QW_BYTES = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              chainStart,
  input logic              tagValid,
  input logic [2:0]        tagId,
  input logic [ADDR_W-1:0] tagAddr,
  input logic              qwStep,
  input logic [ADDR_W-1:0] dataPtr,
  input logic [ADDR_W-1:0] tagPtr,
  input logic [QWC_W-1:0]  qwcLeft,
  input logic              chainEnd
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(QW_BYTES);
  logic tagGo;
  assign tagGo = tagValid && !chainStart;

  AST_STOP_HOLDS_TAG: assert property (@(posedge clk) disable iff (!rstN)
    tagGo && tagId == 3'd7 |=> tagPtr == $past(tagPtr) && chainEnd); // R8
  AST_REFLAST_STEPS_TAG: assert property (@(posedge clk) disable iff (!rstN)
    tagGo && tagId == 3'd0 |=> tagPtr == $past(tagPtr) + STEP && chainEnd); // R4
  AST_COUNT_TRACKS: assert property (@(posedge clk) disable iff (!rstN)
    tagGo && tagId == 3'd1 |=> tagPtr == dataPtr && dataPtr == $past(tagPtr) + STEP); // R5
  AST_JUMP_LOADS_TAG: assert property (@(posedge clk) disable iff (!rstN)
    tagGo && tagId == 3'd2 |=> tagPtr == $past(tagAddr)); // R6
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    qwcLeft == '0 && qwStep && !tagValid && !chainStart |=> qwcLeft == '0 && $stable(dataPtr)); // R9
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    chainStart |=> !chainEnd && qwcLeft == '0); // R2
endmodule

bind dma_chain_seq dma_chain_seq_checker #(.ADDR_W(ADDR_W), .QWC_W(QWC_W), .QW_BYTES(QW_BYTES)) chk_i (
  .clk(clk), .rstN(rstN), .chainStart(chainStart), .tagValid(tagValid), .tagId(tagId),
  .tagAddr(tagAddr), .qwStep(qwStep), .dataPtr(dataPtr), .tagPtr(tagPtr),
  .qwcLeft(qwcLeft), .chainEnd(chainEnd)
);

// File: tb/dma_chain_seq_tb_top.sv
module dma_chain_seq_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        chainStart = 1'b0;
  logic [31:0] startPtr = '0;
  logic        tagValid = 1'b0;
  logic [2:0]  tagId = '0;
  logic [15:0] tagQwc = '0;
  logic [31:0] tagAddr = '0;
  logic        qwStep = 1'b0;
  logic        dataDone = 1'b0;
  logic [31:0] dataPtr, tagPtr;
  logic [15:0] qwcLeft;
  logic        chainEnd;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  dma_chain_seq dut_i (
    .clk(clk), .rstN(rstN), .chainStart(chainStart), .startPtr(startPtr),
    .tagValid(tagValid), .tagId(tagId), .tagQwc(tagQwc), .tagAddr(tagAddr),
    .qwStep(qwStep), .dataDone(dataDone), .dataPtr(dataPtr), .tagPtr(tagPtr),
    .qwcLeft(qwcLeft), .chainEnd(chainEnd)
  );

  typedef struct {
    string       req;
    logic [31:0] madr;
    logic [31:0] tadr;
    logic [15:0] left;
    logic        fin;
  } expItem_t;

  expItem_t expQ[$];

  // Reference state, kept from the requirements
  logic [31:0] mData = '0, mTag = '0;
  logic [15:0] mLeft = '0;
  logic        mEnd = 1'b0, mCount = 1'b0;

  task automatic compare(string req, logic [31:0] m, logic [31:0] t, logic [15:0] l, logic f);
    checks++;
    if (dataPtr !== m || tagPtr !== t || qwcLeft !== l || chainEnd !== f) begin
      errors++;
      $display("FAIL %s: got data=%h tag=%h left=%0d end=%b, expected data=%h tag=%h left=%0d end=%b",
               req, dataPtr, tagPtr, qwcLeft, chainEnd, m, t, l, f);
    end
  endtask

  task automatic drive(string req, logic st, logic [31:0] sp, logic tv, logic [2:0] id,
                       logic [15:0] q, logic [31:0] a, logic stp, logic dd);
    expItem_t e;
    @(negedge clk);
    chainStart = st; startPtr = sp; tagValid = tv; tagId = id;
    tagQwc = q; tagAddr = a; qwStep = stp; dataDone = dd;
    if (st) begin
      mTag = sp; mLeft = '0; mEnd = 1'b0; mCount = 1'b0;
    end else if (tv) begin
      if (id == 3'd4 || id == 3'd5 || id == 3'd6) begin
        mEnd = 1'b1; mCount = 1'b0;
      end else begin
        mLeft = q; mCount = (id == 3'd1);
        case (id)
          3'd0: begin mData = a; mTag = mTag + 32'd16; mEnd = 1'b1; end
          3'd1: begin mData = mTag + 32'd16; mTag = mData; mEnd = 1'b0; end
          3'd2: begin mData = mTag + 32'd16; mTag = a; mEnd = 1'b0; end
          3'd3: begin mData = a; mTag = mTag + 32'd16; mEnd = 1'b0; end
          default: begin mData = mTag + 32'd16; mEnd = 1'b1; end
        endcase
      end
    end else begin
      if (stp && mLeft != 0) begin mData = mData + 32'd16; mLeft = mLeft - 16'd1; end
      if (dd && mCount) mTag = mData;
    end
    e.req = req; e.madr = mData; e.tadr = mTag; e.left = mLeft; e.fin = mEnd;
    expQ.push_back(e);
  endtask

  task automatic idle(string req);
    drive(req, 0, '0, 0, 3'd0, '0, '0, 0, 0);
  endtask

  // Monitor: compare after each edge that follows a driven cycle
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (expQ.size() > 0) begin
        expItem_t e;
        e = expQ.pop_front();
        compare(e.req, e.madr, e.tadr, e.left, e.fin);
      end
    end
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 compare("R1 in reset", '0, '0, '0, 1'b0);
    @(negedge clk); rstN = 1'b1;
    idle("R1 after reset");
    drive("R2 start", 1, 32'h1000, 0, 3'd0, '0, '0, 0, 0);
    drive("R5 count tag", 0, '0, 1, 3'd1, 16'd3, 32'hDEAD0, 0, 0);
    drive("R9 step", 0, '0, 0, 3'd0, '0, '0, 1, 0);
    drive("R9 step", 0, '0, 0, 3'd0, '0, '0, 1, 0);
    drive("R9 step last", 0, '0, 0, 3'd0, '0, '0, 1, 0);
    drive("R9 step at zero ignored", 0, '0, 0, 3'd0, '0, '0, 1, 0);
    drive("R10 count done follows", 0, '0, 0, 3'd0, '0, '0, 0, 1);
    drive("R6 jump tag", 0, '0, 1, 3'd2, 16'd2, 32'h2000, 0, 0);
    drive("R9 step after jump", 0, '0, 0, 3'd0, '0, '0, 1, 0);
    drive("R10 done after jump no effect", 0, '0, 0, 3'd0, '0, '0, 0, 1);
    drive("R7 ref tag", 0, '0, 1, 3'd3, 16'd1, 32'h8000, 0, 0);
    drive("R10 done after ref no effect", 0, '0, 0, 3'd0, '0, '0, 1, 1);
    drive("R3 unsupported code 5", 0, '0, 1, 3'd5, 16'd9, 32'hAAAA0, 1, 1);
    drive("R3 unsupported then done ignored", 0, '0, 0, 3'd0, '0, '0, 0, 1);
    drive("R5 count tag again", 0, '0, 1, 3'd1, 16'd2, 32'h0, 0, 0);
    drive("R9 step", 0, '0, 0, 3'd0, '0, '0, 1, 0);
    drive("R10 step and done same cycle", 0, '0, 0, 3'd0, '0, '0, 1, 1);
    drive("R4 ref-and-stop tag", 0, '0, 1, 3'd0, 16'd1, 32'h9000, 0, 0);
    idle("R11 end holds");
    idle("R11 end holds");
    drive("R2 start beats tag", 1, 32'h3000, 1, 3'd3, 16'd4, 32'h5000, 1, 1);
    drive("R8 stop tag", 0, '0, 1, 3'd7, 16'd2, 32'h7000, 0, 0);
    drive("R12 tag beats step", 0, '0, 1, 3'd1, 16'd5, 32'h0, 1, 1);
    drive("R9 step", 0, '0, 0, 3'd0, '0, '0, 1, 0);
    drive("R3 unsupported code 4", 0, '0, 1, 3'd4, 16'd1, 32'h0, 0, 0);
    drive("R3 unsupported code 6", 0, '0, 1, 3'd6, 16'd1, 32'h0, 1, 0);
    drive("R8 stop tag after unsupported", 0, '0, 1, 3'd7, 16'd0, 32'h0, 0, 0);
    drive("R9 step at zero after stop", 0, '0, 0, 3'd0, '0, '0, 1, 0);
    idle("R11 final idle");
    idle("R11 final idle");
    @(posedge clk); #2;
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule